// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, given as a segment number plus an offset inside that segment, into a physical address. Software first programs two configuration registers. One holds the byte address of a segment table in memory. The other holds the number of entries in that table. Each table entry is a two-word descriptor. It carries the segment's physical start address, its length, a valid flag and three permission bits.

A requester presents one request at a time: a segment number, an offset and an access kind (read, write or instruction fetch). The unit checks the segment number against the table length. It then fetches the descriptor through a one-cycle-latency memory read port, or takes it from a single kept copy of the most recently used descriptor. Next it checks the valid flag, the length and the permission. Finally it returns either the physical address or a coded fault.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, req_ready is 1, res_valid and mem_rd_en are 0, both configuration registers are zero (so every request faults as out of range) and no descriptor is kept.
- R2: A segment number not below the table-length register gives fault code 1. No memory read is made, and res_valid rises on the first rising edge after the accepting edge.
- R3: On a descriptor miss, two reads follow on consecutive cycles. The first is at table base + 8 × segment number and returns the base word. The second is 4 bytes higher and returns the limit word. In the limit word, bit 0 permits read, bit 1 permits write, bit 2 permits fetch, bit 3 is the valid flag, and bits 31:4 are the segment length.
- R4: A descriptor whose valid flag is 0 gives fault code 2.
- R5: An offset equal to or above the segment length gives fault code 3.
- R6: The access code is 0 for read, 1 for write, 2 for fetch and 3 reserved. An access whose permission bit is clear, and any reserved access, gives fault code 4.
- R7: A request that passes every check returns fault code 0 and the base plus the zero-extended offset, modulo 2^32. Every faulting result shows physical address 0.
- R8: When several checks fail, the reported cause is the first that fails in the order: range, valid flag, length, permission.
- R9: A request to the same segment as the kept descriptor makes no memory read, and its result appears on the first rising edge after the accepting edge.
- R10: A write to either configuration register discards the kept descriptor, so the next in-range request reads memory again using the new register values.
- R11: Only one request is in flight. req_ready is 0 from acceptance until the result cycle. On a miss, res_valid rises on the fourth rising edge after the accepting edge and stays high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_we | input | 1 | Write strobe for the table base register |
| cfg_base_wdata | input | 32 | New table base (byte address) |
| cfg_len_we | input | 1 | Write strobe for the table-length register |
| cfg_len_wdata | input | SEG_W+1 | New number of table entries |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_seg | input | SEG_W | Segment number |
| req_ofs | input | 28 | Offset in the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor word byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 3 | 0 none, 1 range, 2 invalid, 3 length, 4 permission |
| res_paddr | output | 32 | Physical address, 0 on fault |

## Verification
Translation is tried on in-range segments with offsets just below and exactly at the length. This separates a correct length compare from an off-by-one error. Each access kind is applied against descriptors whose permission sets differ, and a reserved access is also applied. Descriptors that fail two checks at once show whether the priority order is kept. A base near the top of the address space shows that the sum wraps. Repeated, alternating and post-configuration requests are told apart by the number of memory reads and by result latency. This shows whether the kept descriptor is used, replaced and discarded correctly.

// File: rtl/seg_xlate_pkg.sv
// Shared codes for the segment translation unit.
// Assumes: fault and access codes are visible at the ports as plain vectors.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PRIV    = 3'd4
    } fault_e;

    // Low bits of the limit word that carry flags rather than length.
    localparam int unsigned FLAG_BITS = 4;
    localparam int unsigned VALID_BIT = 3;
endpackage

// File: rtl/seg_rule_check.sv
// Purely combinational descriptor checks: valid flag, length, permission,
// in that priority, and the base + offset sum for a passing access.
// Assumes: limit word layout {length, valid, fetch, write, read}.
module seg_rule_check
    import seg_xlate_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    localparam int unsigned OFS_W = WORD_W - FLAG_BITS
) (
    input  logic [WORD_W-1:0] base_word,
    input  logic [WORD_W-1:0] lim_word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        acc,
    output logic [2:0]        fault,
    output logic [WORD_W-1:0] paddr
);
    logic [OFS_W-1:0] seg_len;
    logic             perm_ok;

    assign seg_len = lim_word[WORD_W-1:FLAG_BITS];

    // Select the permission bit that matches the access kind.
    always_comb begin
        unique case (acc)
            ACC_READ:  perm_ok = lim_word[0];
            ACC_WRITE: perm_ok = lim_word[1];
            ACC_FETCH: perm_ok = lim_word[2];
            default:   perm_ok = 1'b0;
        endcase
    end

    // Prioritised fault selection and address formation.
    always_comb begin
        paddr = '0;
        if (!lim_word[VALID_BIT]) begin
            fault = FLT_INVALID;
        end else if (ofs >= seg_len) begin
            fault = FLT_LIMIT;
        end else if (!perm_ok) begin
            fault = FLT_PRIV;
        end else begin
            fault = FLT_NONE;
            paddr = base_word + {{FLAG_BITS{1'b0}}, ofs};
        end
    end
endmodule

// File: rtl/seg_desc_cache.sv
// Single-entry store for the most recently fetched descriptor and its
// segment number. Base and limit words fill on separate cycles; the entry
// becomes valid with the limit word. A flush wins over a fill.
module seg_desc_cache #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_base_en,
    input  logic              fill_lim_en,
    input  logic [WORD_W-1:0] fill_data,
    input  logic [SEG_W-1:0]  fill_seg,
    input  logic [SEG_W-1:0]  lookup_seg,
    output logic              hit,
    output logic              entry_vld,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] lim_q
);
    logic [SEG_W-1:0] seg_tag;

    // Hold descriptor words, tag and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_vld <= 1'b0;
            seg_tag   <= '0;
            base_q    <= '0;
            lim_q     <= '0;
        end else begin
            if (fill_base_en) base_q <= fill_data;
            if (fill_lim_en) begin
                lim_q   <= fill_data;
                seg_tag <= fill_seg;
            end
            if (flush)            entry_vld <= 1'b0;
            else if (fill_lim_en) entry_vld <= 1'b1;
        end
    end

    assign hit = entry_vld && (seg_tag == lookup_seg);
endmodule

// File: rtl/seg_xlate_unit.sv
// Segment translation top: configuration registers, request sequencer,
// descriptor fetch over a one-cycle-latency read port and result register.
// Assumes: configuration is written only while req_ready is high and no
// request is being presented; memory data follows a read strobe by one cycle.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int unsigned SEG_W  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned OFS_W = WORD_W - FLAG_BITS,
    localparam int unsigned DESC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_base_we,
    input  logic [WORD_W-1:0] cfg_base_wdata,
    input  logic              cfg_len_we,
    input  logic [SEG_W:0]    cfg_len_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFS_W-1:0]  req_ofs,
    input  logic [1:0]        req_acc,
    output logic              mem_rd_en,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              res_valid,
    output logic [2:0]        res_fault,
    output logic [WORD_W-1:0] res_paddr
);
    typedef enum logic [2:0] {S_IDLE, S_LOOK, S_BASE, S_LIM, S_EVAL} st_e;

    st_e               state;
    logic [WORD_W-1:0] tbl_base_q;
    logic [SEG_W:0]    tbl_len_q;
    logic [SEG_W-1:0]  seg_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [1:0]        acc_q;
    logic              in_range, hit, cache_vld;
    logic [WORD_W-1:0] desc_addr, c_base, c_lim, chk_paddr;
    logic [2:0]        chk_fault;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base_q <= '0;
            tbl_len_q  <= '0;
        end else begin
            if (cfg_base_we) tbl_base_q <= cfg_base_wdata;
            if (cfg_len_we)  tbl_len_q  <= cfg_len_wdata;
        end
    end

    assign req_ready = (state == S_IDLE);
    assign in_range  = ({1'b0, seg_q} < tbl_len_q);
    assign desc_addr = tbl_base_q + (WORD_W'(seg_q) << DESC_SHIFT);
    assign mem_rd_en = ((state == S_LOOK) && in_range && !hit) || (state == S_BASE);
    assign mem_rd_addr = (state == S_BASE) ? desc_addr + WORD_W'(4) : desc_addr;

    seg_desc_cache #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (cfg_base_we || cfg_len_we),
        .fill_base_en (state == S_BASE),
        .fill_lim_en  (state == S_LIM),
        .fill_data    (mem_rd_data),
        .fill_seg     (seg_q),
        .lookup_seg   (seg_q),
        .hit          (hit),
        .entry_vld    (cache_vld),
        .base_q       (c_base),
        .lim_q        (c_lim)
    );

    seg_rule_check #(.WORD_W(WORD_W)) u_check (
        .base_word (c_base),
        .lim_word  (c_lim),
        .ofs       (ofs_q),
        .acc       (acc_q),
        .fault     (chk_fault),
        .paddr     (chk_paddr)
    );

    // Request sequencing and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            seg_q <= '0;
            ofs_q <= '0;
            acc_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    seg_q <= req_seg;
                    ofs_q <= req_ofs;
                    acc_q <= req_acc;
                    state <= S_LOOK;
                end
                S_LOOK:  state <= (in_range && !hit) ? S_BASE : S_IDLE;
                S_BASE:  state <= S_LIM;
                S_LIM:   state <= S_EVAL;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Result register: one-cycle strobe with fault code and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fault <= FLT_NONE;
            res_paddr <= '0;
        end else begin
            res_valid <= 1'b0;
            if (state == S_LOOK && !in_range) begin
                res_valid <= 1'b1;
                res_fault <= FLT_RANGE;
                res_paddr <= '0;
            end else if ((state == S_LOOK && hit) || state == S_EVAL) begin
                res_valid <= 1'b1;
                res_fault <= chk_fault;
                res_paddr <= chk_paddr;
            end
        end
    end
endmodule

// File: rtl/seg_xlate_sva.sv
// Protocol and ordering checks for the segment translation unit,
// attached to every instance of the top by the bind below.
module seg_xlate_sva #(
    parameter int unsigned SEG_W  = 8,
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEG_W-1:0]  req_seg,
    input logic [SEG_W:0]    tbl_len_q,
    input logic              cfg_base_we,
    input logic              cfg_len_we,
    input logic              cache_vld,
    input logic              mem_rd_en,
    input logic [WORD_W-1:0] mem_rd_addr,
    input logic              res_valid,
    input logic [2:0]        res_fault,
    input logic [WORD_W-1:0] res_paddr
);
    logic range_bad_accept;
    assign range_bad_accept = req_valid && req_ready && !cfg_len_we &&
                              ({1'b0, req_seg} >= tbl_len_q);

    // R2: out-of-range request never touches memory.
    p_range_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        range_bad_accept |=> !mem_rd_en);

    // R2: out-of-range request reports code 1 one edge after LOOK.
    p_range_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        range_bad_accept |-> ##2 (res_valid && res_fault == 3'd1));

    // R3: a descriptor read is followed by the limit word 4 bytes higher.
    p_read_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !$past(mem_rd_en)) |=>
            (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + WORD_W'(4)));

    // R3: reads come in pairs, never three in a row.
    p_read_pair_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

    // R7: faulting results carry a zero address.
    p_fault_addr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 3'd0) |-> res_paddr == '0);

    // R8: only defined fault codes appear.
    p_fault_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_fault <= 3'd4);

    // R10: a configuration write drops the kept descriptor.
    p_cfg_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_base_we || cfg_len_we) |=> !cache_vld);

    // R11: a result is never produced while the unit was accepting.
    p_busy_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$past(req_ready));
endmodule

bind seg_xlate_unit seg_xlate_sva #(.SEG_W(SEG_W), .WORD_W(WORD_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_seg     (req_seg),
    .tbl_len_q   (tbl_len_q),
    .cfg_base_we (cfg_base_we),
    .cfg_len_we  (cfg_len_we),
    .cache_vld   (cache_vld),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .res_valid   (res_valid),
    .res_fault   (res_fault),
    .res_paddr   (res_paddr)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each result and queues it, the
// monitor pops and compares whenever the unit reports a result.
module seg_xlate_unit_tb_top;
    localparam int SEG_W = 8;
    localparam int WORD_W = 32;
    localparam int OFS_W = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_base_we = 1'b0, cfg_len_we = 1'b0;
    logic [31:0] cfg_base_wdata = '0;
    logic [SEG_W:0] cfg_len_wdata = '0;
    logic req_valid = 1'b0, req_ready;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFS_W-1:0] req_ofs = '0;
    logic [1:0] req_acc = '0;
    logic mem_rd_en;
    logic [31:0] mem_rd_addr, mem_rd_data = '0;
    logic res_valid;
    logic [2:0] res_fault;
    logic [31:0] res_paddr;

    always #4 clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_ofs(req_ofs), .req_acc(req_acc),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr)
    );

    int errors = 0, checks = 0, cyc = 0, acc_cyc = 0, rd_cnt = 0;
    bit done = 1'b0;
    logic [31:0] mem [64];
    logic [31:0] rd_addr_q[$];
    logic [2:0]  exp_fault_q[$];
    logic [31:0] exp_addr_q[$];
    int          exp_lat_q[$];
    string       exp_tag_q[$];
    bit          m_cv = 1'b0;
    logic [7:0]  m_cs = '0;
    logic [31:0] m_tbl = '0;
    int          m_len = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model with one-cycle read latency, read counter and address log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[7:2]];
            rd_cnt <= rd_cnt + 1;
            rd_addr_q.push_back(mem_rd_addr);
        end
    end

    // Monitor: compare every result with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_fault_q.size() == 0) begin
                chk("R11 unexpected result", 32'd1, 32'd0);
            end else begin
                automatic string tag = exp_tag_q.pop_front();
                chk({tag, " fault"}, 32'(res_fault), 32'(exp_fault_q.pop_front()));
                chk({tag, " paddr"}, res_paddr, exp_addr_q.pop_front());
                chk({tag, " latency R11"}, 32'(cyc - acc_cyc), 32'(exp_lat_q.pop_front()));
            end
        end
    end

    function automatic logic [31:0] lim_word(logic [27:0] len, bit v, logic [2:0] xwr);
        return {len, v, xwr};
    endfunction

    task automatic cfg_base(logic [31:0] v);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base_wdata = v;
        @(negedge clk);
        cfg_base_we = 1'b0;
        m_tbl = v; m_cv = 1'b0;
    endtask

    task automatic cfg_len(int v);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len_wdata = (SEG_W+1)'(v);
        @(negedge clk);
        cfg_len_we = 1'b0;
        m_len = v; m_cv = 1'b0;
    endtask

    // Driver: predict from the requirements, queue, present the request.
    task automatic issue(logic [7:0] seg, logic [27:0] ofs, logic [1:0] acc, string tag);
        logic [2:0] f; logic [31:0] a, bw, lw; int lat, nrd, r0;
        logic [31:0] daddr;
        daddr = m_tbl + {21'd0, seg, 3'd0};
        a = '0;
        if (int'(seg) >= m_len) begin
            f = 3'd1; lat = 1; nrd = 0;
        end else begin
            bit hitp = m_cv && (m_cs == seg);
            lat = hitp ? 1 : 4; nrd = hitp ? 0 : 2;
            m_cv = 1'b1; m_cs = seg;
            bw = mem[daddr[7:2]]; lw = mem[daddr[7:2] + 6'd1];
            if (!lw[3])                      f = 3'd2;
            else if (ofs >= lw[31:4])        f = 3'd3;
            else if (acc == 2'd3 || !lw[acc]) f = 3'd4;
            else begin f = 3'd0; a = bw + {4'd0, ofs}; end
        end
        exp_fault_q.push_back(f); exp_addr_q.push_back(a);
        exp_lat_q.push_back(lat); exp_tag_q.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = rd_cnt; rd_addr_q.delete();
        req_seg = seg; req_ofs = ofs; req_acc = acc; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_cyc = cyc; req_valid = 1'b0;
        while (exp_fault_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk({tag, " read count R9"}, 32'(rd_cnt - r0), 32'(nrd));
        if (nrd == 2) chk({tag, " descriptor address R3"}, rd_addr_q[0], daddr);
    endtask

    initial begin
        foreach (mem[i]) mem[i] = '0;
        // table at 0x40: segments 0..3
        mem[16] = 32'h1000_0000; mem[17] = lim_word(28'h100, 1'b1, 3'b001);
        mem[18] = 32'h2000_0000; mem[19] = lim_word(28'h040, 1'b1, 3'b110);
        mem[20] = 32'h0000_3000; mem[21] = lim_word(28'h010, 1'b0, 3'b111);
        mem[22] = 32'hFFFF_FFF0; mem[23] = lim_word(28'h080, 1'b1, 3'b111);
        // second table at 0x80: segment 3 only
        mem[38] = 32'h5000_0000; mem[39] = lim_word(28'h080, 1'b1, 3'b111);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 mem_rd_en", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;
        issue(8'd0, 28'h0, 2'd0, "R1 zero length range");

        cfg_base(32'h40);
        cfg_len(4);
        issue(8'd0, 28'h20, 2'd0, "R7 R3 seg0 read miss");
        issue(8'd0, 28'hFF, 2'd0, "R9 seg0 hit below length");
        issue(8'd0, 28'h100, 2'd0, "R5 seg0 at length");
        issue(8'd0, 28'h10, 2'd1, "R6 seg0 write denied");
        issue(8'd1, 28'h3F, 2'd2, "R7 seg1 fetch");
        issue(8'd1, 28'h3F, 2'd1, "R7 seg1 write hit");
        issue(8'd1, 28'h00, 2'd0, "R6 seg1 read denied");
        issue(8'd1, 28'h40, 2'd0, "R8 length before permission");
        issue(8'd2, 28'h00, 2'd0, "R4 invalid segment");
        issue(8'd2, 28'h20, 2'd3, "R8 invalid before length");
        issue(8'd4, 28'h00, 2'd0, "R2 seg equals length");
        issue(8'd200, 28'h00, 2'd0, "R2 R8 seg far out of range");
        issue(8'd3, 28'h20, 2'd0, "R7 wrap around");
        issue(8'd3, 28'h20, 2'd3, "R6 reserved access");
        issue(8'd0, 28'h01, 2'd0, "R9 alternate back to seg0");
        issue(8'd0, 28'h02, 2'd0, "R9 repeat seg0");
        cfg_len(4);
        issue(8'd0, 28'h03, 2'd0, "R10 refetch after length write");
        issue(8'd3, 28'h10, 2'd1, "R10 seg3 from old table");
        cfg_base(32'h80);
        issue(8'd3, 28'h10, 2'd1, "R10 seg3 from new table");
        cfg_len(2);
        issue(8'd3, 28'h10, 2'd0, "R2 shortened table");

        repeat (5) @(negedge clk);
        chk("R11 no pending predictions", 32'(exp_fault_q.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule